// File: doc/BRIEF.md
# Ultraviolet-Erasable Memory Model with Mode Decoding

This block models, at the logic level, a byte-wide memory that can only be programmed from ones towards zeros and is returned to all ones by a global erase. Three control levels decide what it does: an active-low chip select, an active-low output gate and a flag saying that the programming voltage is present. The chip select and the voltage flag together choose between standby, reading (also used as verify after programming), programming and program inhibit. The output gate only matters for reading. A programming step is a low pulse on the chip select while the voltage flag is high. Its width is counted in clock cycles and the write is committed when the chip select returns high.

A controller state machine has four states. SWEEP writes all ones into one location per cycle and keeps `busy_o` high. IDLE waits for work. PULSE counts a programming pulse. HELD waits out a pulse that ran too long. The transitions are as follows:
- Reset enters SWEEP. SWEEP goes to IDLE after the last location.
- IDLE goes to SWEEP on `erase_i`. Erase has priority in IDLE.
- IDLE goes to PULSE when the decoded mode is programming.
- PULSE goes to IDLE on release. The write is committed if the width is in range and flagged otherwise.
- PULSE goes to IDLE with an error if the voltage flag drops.
- PULSE goes to HELD with an error when the width limit is passed.
- HELD goes to IDLE once the chip select rises or the voltage flag drops.

Any bad pulse sets a sticky error flag, and only reset clears it.

Top module: `uvrom_model`

## Requirements
- R1: Reset starts an erase sweep. After reset is released, and after any `erase_i` accepted in IDLE, `busy_o` is high for exactly 2**ADDR_W clock edges. Afterwards every location reads 8'hFF.
- R2: Read/verify mode is chip select low, output gate low, voltage flag low and not busy. In this mode `drive_o` is 1 and `data_o` shows the word at `addr_i` in the same cycle.
- R3: Standby is chip select high with the voltage flag low. In standby `drive_o` is 0 and `data_o` is 8'h00.
- R4: With the chip select low, the output gate high and the voltage flag low, `drive_o` is 0 and `data_o` is 8'h00.
- R5: A program pulse has the voltage flag high and the chip select low for PULSE_MIN to PULSE_MAX consecutive clock edges. Address and data are captured on its first low edge. At the first edge with the chip select high, the location becomes old AND data, so bits can only go from 1 to 0.
- R6: With the voltage flag high and the chip select high (program inhibit), no location changes and `drive_o` is 0. While the voltage flag is high, `drive_o` is 0 in every case.
- R7: A pulse of fewer than PULSE_MIN low edges writes nothing and sets `err_o`.
- R8: A chip select held low with the voltage flag high for more than PULSE_MAX edges sets `err_o` and writes nothing.
- R9: `err_o` stays high once set until reset.
- R10: If the voltage flag drops while a pulse is in progress, the pulse is abandoned without a write and `err_o` is set.
- R11: While `busy_o` is high, program pulses and `erase_i` are ignored, and `drive_o` is 0.
- R12: Locations may be programmed in any address order. Each write affects only its own location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| ce_n_i | input | 1 | Chip select, active low; carries the program pulse |
| oe_n_i | input | 1 | Output gate, active low |
| vpp_i | input | 1 | Programming voltage present |
| data_i | input | DATA_W | Data to program |
| erase_i | input | 1 | Global erase request |
| data_o | output | DATA_W | Read data, zero when not driving |
| drive_o | output | 1 | Output would be driven |
| busy_o | output | 1 | Erase sweep in progress |
| err_o | output | 1 | Sticky bad-pulse flag |

## Verification
The bench builds the block with ADDR_W=6, PULSE_MIN=3 and PULSE_MAX=6. With a 64-word array, a full erase sweep lasts only 64 cycles, so the sweep length, a pulse attempted during a sweep and a complete read-back of every word all fit in a short run. The narrow pulse window brings within reach the exact boundaries at both ends: widths 2, 3, 6 and 7 cycles. It also covers a voltage drop in the middle of a pulse.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;

    // Decoded operating mode of the control pins
    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_READ,
        MODE_OUTOFF,
        MODE_PROGRAM,
        MODE_INHIBIT
    } mode_e;

    // Programming controller states
    typedef enum logic [1:0] {
        ST_SWEEP,
        ST_IDLE,
        ST_PULSE,
        ST_HELD
    } pstate_e;

endpackage

// File: rtl/uvrom_mode_decode.sv
module uvrom_mode_decode
    import uvrom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp,
    output mode_e mode
);

    always_comb begin
        unique case ({vpp, ce_n})
            2'b11:   mode = MODE_INHIBIT;
            2'b10:   mode = MODE_PROGRAM;
            2'b01:   mode = MODE_STANDBY;
            2'b00:   mode = oe_n ? MODE_OUTOFF : MODE_READ;
            default: mode = MODE_STANDBY;
        endcase
    end

endmodule

// File: rtl/uvrom_cell_array.sv
module uvrom_cell_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] old_word;

    assign old_word = mem[wr_addr];
    assign rd_data  = mem[rd_addr];

    // Erase writes ones; programming can only clear bits
    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[wr_addr] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= old_word & wr_data;
        end
    end

    AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !clr_en |=> ((mem[$past(wr_addr)] & ~$past(old_word)) == '0)); // R5

endmodule

// File: rtl/uvrom_prog_ctrl.sv
module uvrom_prog_ctrl
    import uvrom_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int PULSE_MIN = 45,
    parameter int PULSE_MAX = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              err_o,
    output logic              clr_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int CNT_W = $clog2(PULSE_MAX + 1) + 1;
    localparam logic [CNT_W-1:0]  CNT_MIN  = CNT_W'(PULSE_MIN);
    localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(PULSE_MAX);
    localparam logic [ADDR_W-1:0] IDX_LAST = '1;

    pstate_e           state, state_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] sweep_idx;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              cap, cnt_inc, err_set;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SWEEP;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_nxt = state;
        clr_en    = 1'b0;
        wr_en     = 1'b0;
        cap       = 1'b0;
        cnt_inc   = 1'b0;
        err_set   = 1'b0;
        unique case (state)
            ST_SWEEP: begin
                clr_en = 1'b1;
                if (sweep_idx == IDX_LAST) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (erase_i) begin
                    state_nxt = ST_SWEEP;
                end else if (mode == MODE_PROGRAM) begin
                    cap       = 1'b1;
                    state_nxt = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (mode == MODE_INHIBIT) begin
                    if (cnt >= CNT_MIN) begin
                        wr_en = 1'b1;
                    end else begin
                        err_set = 1'b1;
                    end
                    state_nxt = ST_IDLE;
                end else if (mode != MODE_PROGRAM) begin
                    err_set   = 1'b1;
                    state_nxt = ST_IDLE;
                end else if (cnt == CNT_MAX) begin
                    err_set   = 1'b1;
                    state_nxt = ST_HELD;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_HELD: begin
                if (mode != MODE_PROGRAM) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Pulse width counter and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            lat_addr <= '0;
            lat_data <= '0;
        end else if (cap) begin
            cnt      <= CNT_W'(1);
            lat_addr <= addr_i;
            lat_data <= data_i;
        end else if (cnt_inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Sweep pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep_idx <= '0;
        end else if (state == ST_SWEEP) begin
            sweep_idx <= sweep_idx + ADDR_W'(1);
        end else begin
            sweep_idx <= '0;
        end
    end

    // Sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (err_set) begin
            err_o <= 1'b1;
        end
    end

    assign busy_o  = (state == ST_SWEEP);
    assign wr_addr = clr_en ? sweep_idx : lat_addr;
    assign wr_data = lat_data;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R9
    AST_WIDTH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cnt >= CNT_MIN) && (cnt <= CNT_MAX)); // R7
    AST_WRITE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (mode == MODE_INHIBIT) && ($past(mode) == MODE_PROGRAM)); // R5
    AST_OVERLONG_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) && (mode == MODE_PROGRAM) && (cnt == CNT_MAX) |=> err_o); // R8
    AST_SWEEP_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && erase_i |=> !wr_en); // R11

endmodule

// File: rtl/uvrom_model.sv
module uvrom_model
    import uvrom_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int PULSE_MIN = 45,
    parameter int PULSE_MAX = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              vpp_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              erase_i,
    output logic [DATA_W-1:0] data_o,
    output logic              drive_o,
    output logic              busy_o,
    output logic              err_o
);

    localparam int DEPTH = 1 << ADDR_W;

    mode_e             mode;
    logic              clr_en, wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    uvrom_mode_decode u_decode (
        .ce_n (ce_n_i),
        .oe_n (oe_n_i),
        .vpp  (vpp_i),
        .mode (mode)
    );

    uvrom_prog_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PULSE_MIN (PULSE_MIN),
        .PULSE_MAX (PULSE_MAX)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .erase_i (erase_i),
        .addr_i  (addr_i),
        .data_i  (data_i),
        .busy_o  (busy_o),
        .err_o   (err_o),
        .clr_en  (clr_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    uvrom_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr_i),
        .rd_data (rd_data)
    );

    assign drive_o = (mode == MODE_READ) && !busy_o;
    assign data_o  = drive_o ? rd_data : '0;

    // Sweep length tracker for the erase assertion
    logic [ADDR_W:0] busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy_o) begin
            busy_run <= busy_run + (ADDR_W+1)'(1);
        end else begin
            busy_run <= '0;
        end
    end

    AST_SWEEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> busy_run == (ADDR_W+1)'(DEPTH)); // R1
    AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i && !vpp_i |-> !drive_o && (data_o == '0)); // R3
    AST_GATE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n_i && oe_n_i |-> !drive_o); // R4
    AST_VPP_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_i |-> !drive_o); // R6
    AST_NO_WRITE_WITHOUT_VPP: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_i |-> !wr_en); // R10
    AST_BUSY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !drive_o); // R11

endmodule

// File: tb/uvrom_model_tb.sv
`timescale 1ns/100ps
module uvrom_model_tb;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int PMIN   = 3;
    localparam int PMAX   = 6;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce_n = 1'b1, oe_n = 1'b1, vpp = 1'b0, erase = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] data_o;
    logic              drive_o, busy_o, err_o;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    uvrom_model #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PULSE_MIN (PMIN), .PULSE_MAX (PMAX)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .addr_i (addr), .ce_n_i (ce_n), .oe_n_i (oe_n),
        .vpp_i (vpp), .data_i (din), .erase_i (erase), .data_o (data_o),
        .drive_o (drive_o), .busy_o (busy_o), .err_o (err_o)
    );

    // Behavioural reference model
    int ref_mem [DEPTH];
    int m_left, m_phase, m_low, m_a, m_d;
    bit m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = DEPTH; m_err = 0; m_phase = 0;
            foreach (ref_mem[i]) ref_mem[i] = 255;
        end else if (m_left > 0) begin
            m_left--;
        end else if (m_phase == 0) begin
            if (erase) begin
                m_left = DEPTH;
                foreach (ref_mem[i]) ref_mem[i] = 255;
            end else if (vpp && !ce_n) begin
                m_phase = 1; m_low = 1; m_a = int'(addr); m_d = int'(din);
            end
        end else if (m_phase == 1) begin
            if (!vpp) begin
                m_err = 1; m_phase = 0;
            end else if (ce_n) begin
                if (m_low >= PMIN) ref_mem[m_a] = ref_mem[m_a] & m_d;
                else m_err = 1;
                m_phase = 0;
            end else if (m_low == PMAX) begin
                m_err = 1; m_phase = 2;
            end else begin
                m_low++;
            end
        end else begin
            if (ce_n || !vpp) m_phase = 0;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            logic       e_drive;
            logic [7:0] e_data;
            e_drive = (m_left == 0) && !ce_n && !oe_n && !vpp;
            e_data  = e_drive ? 8'(ref_mem[addr]) : 8'h00;
            checks++;
            if ({drive_o, busy_o, err_o, data_o} !== {e_drive, (m_left > 0), m_err, e_data}) begin
                errors++;
                $display("FAIL %s cycle %0d: drive/busy/err/data act %b/%b/%b/%h exp %b/%b/%b/%h",
                         cur_req, cyc, drive_o, busy_o, err_o, data_o,
                         e_drive, (m_left > 0), m_err, e_data);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act %0d cycles exp <= 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act %0h exp %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; vpp = 1'b0; erase = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy in reset", int'(busy_o), 1);
        chk("R9 err cleared by reset", int'(err_o), 0);
        chk("R11 no drive in reset", int'(drive_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * DEPTH && busy_o; i++) @(negedge clk);
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk);
        addr = ADDR_W'(a); vpp = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        chk(tag, int'(drive_o), 1);
        chk(tag, int'(data_o), exp);
    endtask

    task automatic pulse(input int a, input int d, input int w);
        @(negedge clk);
        oe_n = 1'b1; ce_n = 1'b1; vpp = 1'b1; addr = ADDR_W'(a); din = DATA_W'(d);
        @(negedge clk);
        ce_n = 1'b0;
        repeat (w) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        vpp = 1'b0;
    endtask

    initial begin
        int n;
        cur_req = "R1";
        do_reset();
        n = 0;
        while (busy_o && n < 4 * DEPTH) begin
            @(negedge clk); #1; n++;
        end
        // busy seen high at n-1 sampled points after release plus the first
        chk("R1 sweep length after reset", n, DEPTH);
        cur_req = "R2";
        for (int i = 0; i < DEPTH; i++) rd(i, 8'hFF, "R1 blank after reset");

        cur_req = "R3";
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; vpp = 1'b0; addr = 6'd3; #1;
        chk("R3 standby drive", int'(drive_o), 0);
        chk("R3 standby data", int'(data_o), 0);

        cur_req = "R4";
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1;
        chk("R4 gate high drive", int'(drive_o), 0);

        cur_req = "R5";
        pulse(5, 8'hA5, 4);
        rd(5, 8'hA5, "R5 first program");
        pulse(5, 8'h0F, PMIN);
        rd(5, 8'h05, "R5 AND with old, min width");
        pulse(63, 8'h3C, PMAX);
        rd(63, 8'h3C, "R5 max width");
        pulse(63, 8'hFF, 4);
        rd(63, 8'h3C, "R5 ones leave bits");
        chk("R5 no error on good pulses", int'(err_o), 0);

        cur_req = "R12";
        pulse(40, 8'h11, 4);
        pulse(2, 8'h22, 5);
        pulse(33, 8'h44, 3);
        pulse(17, 8'h88, 6);
        rd(40, 8'h11, "R12 random order 40");
        rd(2, 8'h22, "R12 random order 2");
        rd(33, 8'h44, "R12 random order 33");
        rd(17, 8'h88, "R12 random order 17");
        rd(41, 8'hFF, "R12 neighbour untouched");
        rd(16, 8'hFF, "R12 neighbour untouched");

        cur_req = "R6";
        @(negedge clk); addr = 6'd9; din = 8'h00; oe_n = 1'b0; vpp = 1'b1; ce_n = 1'b1;
        repeat (5) begin
            @(negedge clk); #1;
            chk("R6 inhibit float", int'(drive_o), 0);
        end
        @(negedge clk); vpp = 1'b0;
        rd(9, 8'hFF, "R6 inhibit no write");

        cur_req = "R7";
        pulse(20, 8'h00, PMIN - 1);
        rd(20, 8'hFF, "R7 short pulse no write");
        chk("R7 short pulse error", int'(err_o), 1);
        cur_req = "R9";
        pulse(21, 8'h70, 4);
        rd(21, 8'h70, "R9 later write still works");
        chk("R9 error sticky", int'(err_o), 1);

        cur_req = "R8";
        do_reset();
        wait_idle();
        pulse(12, 8'h00, PMAX + 1);
        rd(12, 8'hFF, "R8 overlong no write");
        chk("R8 overlong error", int'(err_o), 1);

        cur_req = "R10";
        do_reset();
        wait_idle();
        @(negedge clk); oe_n = 1'b1; vpp = 1'b1; ce_n = 1'b1; addr = 6'd7; din = 8'h00;
        @(negedge clk); ce_n = 1'b0;
        repeat (2) @(negedge clk);
        vpp = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
        rd(7, 8'hFF, "R10 voltage drop no write");
        chk("R10 voltage drop error", int'(err_o), 1);

        cur_req = "R11";
        do_reset();
        wait_idle();
        pulse(30, 8'h0A, 4);
        rd(30, 8'h0A, "R11 setup write");
        @(negedge clk); erase = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); erase = 1'b0; #1;
        chk("R1 erase starts sweep", int'(busy_o), 1);
        pulse(31, 8'h00, 4);
        @(negedge clk); erase = 1'b1; addr = 6'd30; ce_n = 1'b0; oe_n = 1'b0; #1;
        chk("R11 no drive while busy", int'(drive_o), 0);
        @(negedge clk); erase = 1'b0; ce_n = 1'b1;
        wait_idle();
        @(negedge clk); #1;
        chk("R11 erase ignored while busy", int'(busy_o), 0);
        rd(31, 8'hFF, "R11 pulse ignored while busy");
        rd(30, 8'hFF, "R1 erased word");
        chk("R11 no error from ignored pulse", int'(err_o), 0);

        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule